// File: doc/BRIEF.md
# Sideband Calibration Sequencer

This block sits on the master side of a source-synchronous sideband address bus and opens a calibration window for the sideband I/O buffers. A calibration cycle on the main bus completes when the calibration indication, initiator ready and target ready are all high at the same clock edge. In the next cycle the block stops the sideband strobe pair. It then drives the sideband data lines and both strobe lines low.

The stopped period has two phases. The first is a fixed detection interval. The far end needs this time to notice that the strobes have stopped, so no compensation update may be applied during it. The second is an update interval, during which the local buffer compensation logic is granted its requests. The update interval has a fixed minimum length plus an extension count that is captured at the trigger. When the update interval ends, the strobes restart on a clean cycle boundary and normal sideband traffic passes through again. A one-cycle done pulse follows the restart.

Top module: `sbcal_seq`

## Requirements
- R1: The sequence starts only when `cal_cyc_i`, `irdy_i` and `trdy_i` are all 1 at the same rising edge while the block is running. From the next cycle on, `busy_o` is 1. If any one of the three inputs is 0, the block keeps running.
- R2: While stopped, `sb_o` is all zeros (the NOP value), both `sb_stb_o` and `sb_stb_n_o` are 0, and `busy_o` is 1.
- R3: The stopped period lasts exactly DET_CYC + UPD_MIN + ext cycles. Here ext is the captured extension, and the defaults are 6 + 2 + ext, so the period is never shorter than 8 cycles.
- R4: During the first DET_CYC stopped cycles (the detection window), `upd_en_o` and `comp_gnt_o` are 0, even when `comp_req_i` is 1.
- R5: `upd_en_o` is 1 for exactly UPD_MIN + ext cycles, immediately following the detection window and ending as the strobes restart.
- R6: `comp_gnt_o` equals `comp_req_i` while `upd_en_o` is 1 and is 0 at all other times.
- R7: `ext_cnt_i` is captured at the trigger edge. Changes to it later in the sequence do not alter the window length.
- R8: While running, `sb_stb_o` toggles every cycle and `sb_stb_n_o` is its complement. In the first running cycle after a stop, `sb_stb_o` is 1 and `sb_stb_n_o` is 0.
- R9: While running, `sb_o` shows the value `sb_data_i` had at the previous rising edge.
- R10: `done_o` is a one-cycle pulse in the second running cycle after the restart.
- R11: A trigger that arrives while a sequence is in progress is ignored and does not change the sequence's length.
- R12: During reset, `sb_o` is 0, `sb_stb_o` is 0, `sb_stb_n_o` is 1, and `busy_o`, `upd_en_o`, `comp_gnt_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_cyc_i | input | 1 | Current bus cycle is a calibration cycle |
| irdy_i | input | 1 | Initiator ready |
| trdy_i | input | 1 | Target ready |
| ext_cnt_i | input | EXT_W (4) | Extra update-window cycles |
| sb_data_i | input | SB_W (8) | Normal sideband traffic |
| comp_req_i | input | 1 | Compensation logic requests an update |
| sb_o | output | SB_W (8) | Sideband data lines |
| sb_stb_o | output | 1 | Sideband strobe |
| sb_stb_n_o | output | 1 | Complement sideband strobe |
| busy_o | output | 1 | Calibration sequence in progress |
| upd_en_o | output | 1 | Update window open |
| comp_gnt_o | output | 1 | Grant for a compensation update |
| done_o | output | 1 | Sequence-finished pulse |

## Verification
The bench builds the block with its default parameters: a 6-cycle detection window, a 2-cycle minimum update window, a 4-bit extension and an 8-bit data path. With these values the whole extension range from 0 to 15 can be reached, so stopped periods from the 8-cycle minimum up to 23 cycles are exercised. The longest period leaves the counter at its widest load. Random sequences also re-raise the trigger and change the extension mid-sequence, which probes the counter reload and the capture of the extension.

// File: rtl/sbcal_pkg.sv
package sbcal_pkg;

    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_DET = 2'd1,
        ST_UPD = 2'd2
    } sbcal_state_e;

endpackage

// File: rtl/sbcal_trig.sv
module sbcal_trig (
    input  logic cal_cyc_i,
    input  logic irdy_i,
    input  logic trdy_i,
    output logic start_o
);
    // Calibration cycle is complete once both sides signal ready
    always_comb begin
        start_o = cal_cyc_i && irdy_i && trdy_i;
    end
endmodule

// File: rtl/sbcal_fsm.sv
module sbcal_fsm
    import sbcal_pkg::*;
#(
    parameter int DET_CYC = 6,
    parameter int UPD_MIN = 2,
    parameter int EXT_W   = 4,
    parameter int SB_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [EXT_W-1:0] ext_i,
    input  logic [SB_W-1:0]  sb_data_i,
    output sbcal_state_e     state_o,
    output logic             ph_o,
    output logic [SB_W-1:0]  sb_o,
    output logic             done_o
);
    localparam int EXT_MAX = (1 << EXT_W) - 1;
    localparam int UPD_MAX = UPD_MIN + EXT_MAX;
    localparam int CNT_MAX = (DET_CYC > UPD_MAX) ? DET_CYC : UPD_MAX;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int LOW_W   = CNT_W + 1;
    localparam int LOW_MIN = DET_CYC + UPD_MIN;

    typedef struct packed {
        sbcal_state_e     st;
        logic [CNT_W-1:0] cnt;
        logic [EXT_W-1:0] ext;
        logic             ph;
        logic [SB_W-1:0]  sb;
        logic             fresh;
        logic             done;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d       = q;
        d.fresh = 1'b0;
        d.done  = q.fresh;
        case (q.st)
            ST_RUN: begin
                if (start_i) begin
                    d.st  = ST_DET;
                    d.cnt = CNT_W'(DET_CYC - 1);
                    d.ext = ext_i;
                end
            end
            ST_DET: begin
                if (q.cnt == '0) begin
                    d.st  = ST_UPD;
                    d.cnt = CNT_W'(UPD_MIN - 1) + CNT_W'(q.ext);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_UPD: begin
                if (q.cnt == '0) begin
                    d.st    = ST_RUN;
                    d.fresh = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_RUN;
        endcase
        // strobe phase restarts from low so the first running cycle drives high
        d.ph = (d.st == ST_RUN) ? ~q.ph : 1'b0;
        d.sb = (d.st == ST_RUN) ? sb_data_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_RUN;
            q.cnt   <= '0;
            q.ext   <= '0;
            q.ph    <= 1'b0;
            q.sb    <= '0;
            q.fresh <= 1'b0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state_o = q.st;
    assign ph_o    = q.ph;
    assign sb_o    = q.sb;
    assign done_o  = q.done;

    // stopped-cycle counter used only by the window-length check
    logic [LOW_W-1:0] low_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                low_q <= '0;
        else if (q.st != ST_RUN)   low_q <= low_q + 1'b1;
        else                       low_q <= '0;
    end

    assert_start_stops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN && start_i) |=> (q.st == ST_DET));

    assert_min_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_UPD && q.cnt == '0) |-> (int'(low_q) + 1 >= LOW_MIN));

    assert_ext_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_RUN) |=> (q.st == ST_RUN || $stable(q.ext)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    assert_retrig_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DET && q.cnt != '0) |=> (q.st == ST_DET && q.cnt == $past(q.cnt) - 1'b1));

endmodule

// File: rtl/sbcal_drive.sv
module sbcal_drive
    import sbcal_pkg::*;
#(
    parameter int SB_W = 8
) (
    input  sbcal_state_e    state_i,
    input  logic            ph_i,
    input  logic [SB_W-1:0] sb_i,
    input  logic            comp_req_i,
    output logic [SB_W-1:0] sb_o,
    output logic            stb_o,
    output logic            stb_n_o,
    output logic            busy_o,
    output logic            upd_en_o,
    output logic            comp_gnt_o
);
    logic running;

    always_comb begin
        running    = (state_i == ST_RUN);
        sb_o       = sb_i;
        stb_o      = running ? ph_i : 1'b0;
        stb_n_o    = running ? ~ph_i : 1'b0;
        busy_o     = !running;
        upd_en_o   = (state_i == ST_UPD);
        comp_gnt_o = upd_en_o && comp_req_i;
    end
endmodule

// File: rtl/sbcal_seq.sv
module sbcal_seq
    import sbcal_pkg::*;
#(
    parameter int DET_CYC = 6,
    parameter int UPD_MIN = 2,
    parameter int EXT_W   = 4,
    parameter int SB_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_cyc_i,
    input  logic             irdy_i,
    input  logic             trdy_i,
    input  logic [EXT_W-1:0] ext_cnt_i,
    input  logic [SB_W-1:0]  sb_data_i,
    input  logic             comp_req_i,
    output logic [SB_W-1:0]  sb_o,
    output logic             sb_stb_o,
    output logic             sb_stb_n_o,
    output logic             busy_o,
    output logic             upd_en_o,
    output logic             comp_gnt_o,
    output logic             done_o
);
    logic            start;
    sbcal_state_e    state;
    logic            ph;
    logic [SB_W-1:0] sb_reg;

    sbcal_trig u_trig (
        .cal_cyc_i (cal_cyc_i),
        .irdy_i    (irdy_i),
        .trdy_i    (trdy_i),
        .start_o   (start)
    );

    sbcal_fsm #(
        .DET_CYC (DET_CYC),
        .UPD_MIN (UPD_MIN),
        .EXT_W   (EXT_W),
        .SB_W    (SB_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .ext_i     (ext_cnt_i),
        .sb_data_i (sb_data_i),
        .state_o   (state),
        .ph_o      (ph),
        .sb_o      (sb_reg),
        .done_o    (done_o)
    );

    sbcal_drive #(
        .SB_W (SB_W)
    ) u_drive (
        .state_i    (state),
        .ph_i       (ph),
        .sb_i       (sb_reg),
        .comp_req_i (comp_req_i),
        .sb_o       (sb_o),
        .stb_o      (sb_stb_o),
        .stb_n_o    (sb_stb_n_o),
        .busy_o     (busy_o),
        .upd_en_o   (upd_en_o),
        .comp_gnt_o (comp_gnt_o)
    );

    assert_stopped_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (sb_o == '0 && !sb_stb_o && !sb_stb_n_o));

    assert_strobe_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sb_stb_o != sb_stb_n_o));

    assert_done_after_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |=> done_o);

endmodule

// File: tb/sbcal_seq_tb.sv
module sbcal_seq_tb;
    localparam int DET_CYC = 6;
    localparam int UPD_MIN = 2;
    localparam int EXT_W   = 4;
    localparam int SB_W    = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cal_cyc_i = 1'b0, irdy_i = 1'b0, trdy_i = 1'b0;
    logic [EXT_W-1:0] ext_cnt_i = '0;
    logic [SB_W-1:0]  sb_data_i = '0;
    logic             comp_req_i = 1'b0;
    logic [SB_W-1:0]  sb_o;
    logic             sb_stb_o, sb_stb_n_o, busy_o, upd_en_o, comp_gnt_o, done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sbcal_seq #(.DET_CYC(DET_CYC), .UPD_MIN(UPD_MIN), .EXT_W(EXT_W), .SB_W(SB_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cal_cyc_i(cal_cyc_i), .irdy_i(irdy_i), .trdy_i(trdy_i),
        .ext_cnt_i(ext_cnt_i), .sb_data_i(sb_data_i), .comp_req_i(comp_req_i),
        .sb_o(sb_o), .sb_stb_o(sb_stb_o), .sb_stb_n_o(sb_stb_n_o), .busy_o(busy_o),
        .upd_en_o(upd_en_o), .comp_gnt_o(comp_gnt_o), .done_o(done_o)
    );

    function automatic int stop_len(int e);
        return DET_CYC + UPD_MIN + e;
    endfunction

    function automatic bit upd_expected(int idx);
        return idx >= DET_CYC;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic run_cycles(int n);
        for (int k = 0; k < n; k++) begin
            logic [SB_W-1:0] v;
            logic prev;
            v = SB_W'($urandom);
            prev = sb_stb_o;
            sb_data_i = v;
            step();
            chk(sb_o == v, "R9 data pass", sb_o, v);
            chk(sb_stb_o != prev && sb_stb_n_o == !sb_stb_o, "R8 toggle", sb_stb_o, !prev);
            chk(!busy_o && !done_o && !upd_en_o, "R1 idle", busy_o, 0);
        end
    endtask

    task automatic run_cal(int e, bit noise);
        int len;
        logic [SB_W-1:0] last;
        len = stop_len(e);
        comp_req_i = 1'b0;
        cal_cyc_i = 1'b1; irdy_i = 1'b1; trdy_i = 1'b1;
        ext_cnt_i = EXT_W'(e);
        last = SB_W'($urandom);
        sb_data_i = last;
        step();
        chk(busy_o, "R1 start", busy_o, 1);
        for (int i = 0; i < len; i++) begin
            chk(sb_o == '0 && !sb_stb_o && !sb_stb_n_o && busy_o, "R2 stopped low",
                {sb_stb_o, sb_stb_n_o, busy_o}, 1);
            chk(upd_en_o == upd_expected(i), upd_expected(i) ? "R5 update window" : "R4 detect lockout",
                upd_en_o, upd_expected(i));
            chk(comp_gnt_o == (upd_expected(i) && comp_req_i), "R6 grant", comp_gnt_o,
                upd_expected(i) && comp_req_i);
            if (noise && i < len - 1) begin
                cal_cyc_i = 1'($urandom); irdy_i = 1'b1; trdy_i = 1'b1;   // R11 retrigger
                ext_cnt_i = EXT_W'($urandom);                              // R7 late change
            end else begin
                cal_cyc_i = 1'b0; irdy_i = 1'b0; trdy_i = 1'b0;
            end
            comp_req_i = 1'($urandom);
            last = SB_W'($urandom);
            sb_data_i = last;
            step();
        end
        cal_cyc_i = 1'b0; irdy_i = 1'b0; trdy_i = 1'b0;
        chk(!busy_o, "R3 window length", busy_o, 0);
        chk(sb_stb_o && !sb_stb_n_o, "R8 restart phase", sb_stb_o, 1);
        chk(!upd_en_o && !comp_gnt_o && !done_o, "R5 window closed", upd_en_o, 0);
        chk(sb_o == last, "R9 resume data", sb_o, last);
        last = SB_W'($urandom);
        sb_data_i = last;
        step();
        chk(done_o, "R10 done pulse", done_o, 1);
        chk(!sb_stb_o && sb_stb_n_o && sb_o == last, "R8 second phase", sb_stb_o, 0);
        step();
        chk(!done_o, "R10 done single", done_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog R3 actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        step(); step();
        // R12 reset state
        chk(sb_o == '0 && !sb_stb_o && sb_stb_n_o, "R12 reset lines", sb_stb_n_o, 1);
        chk(!busy_o && !upd_en_o && !comp_gnt_o && !done_o, "R12 reset flags", busy_o, 0);
        rst_n = 1'b1;
        step();
        run_cycles(4);
        // R1 partial triggers do nothing
        for (int p = 0; p < 3; p++) begin
            cal_cyc_i = (p != 0); irdy_i = (p != 1); trdy_i = (p != 2);
            step();
            chk(!busy_o, "R1 partial trigger", busy_o, 0);
        end
        cal_cyc_i = 1'b0; irdy_i = 1'b0; trdy_i = 1'b0;
        run_cycles(2);
        run_cal(0, 1'b0);   // R3 minimum 8 cycles
        run_cycles(3);
        run_cal(15, 1'b1);  // R3 longest, R7 and R11 noise
        run_cycles(2);
        for (int s = 0; s < 20; s++) begin
            run_cal(int'($urandom % 16), 1'($urandom));
            run_cycles(1 + int'($urandom % 3));
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule